// File: doc/BRIEF.md
# Scalar-to-Vector Move Writeback Unit

This block carries out one scalar move per clock between a file of 64-bit general-purpose registers and two vector register files: a 64-bit short-vector file and a 512-bit wide-vector file. Each request names a source file and a destination file, a width bit, a flag for 64-bit operating mode, a two-bit encoding class, a vector-length bit, a four-bit spare register field, and source and destination indices. Exactly one side of the move must be the general-purpose file. The moved value is 32 or 64 bits wide. The bits above it are cleared or kept according to the destination file and the encoding class.

A request with an illegal combination of fields writes nothing and raises a one-cycle fault pulse. A legal request raises a one-cycle completion pulse. Both pulses are registered and appear in the cycle after the request. A debug port can write any register directly and read any register back with one cycle of latency. It is used to load and inspect the register state.

File codes are 0 for general-purpose, 1 for short-vector, 2 for wide-vector and 3 for none. Encoding codes are 0 for legacy, 1 for the three-byte prefix style, 2 for the four-byte prefix style and 3 for reserved.

Top module: `svmove_unit`

## Requirements
- R1: After synchronous reset, `fault_o`, `done_o` and `dbg_rdata` are all zero.
- R2: A legal 32-bit move into the short-vector file (dst_file=1) writes bits 31:0 from the source and clears bits 63:32. A 64-bit move writes all 64 bits.
- R3: A legal move into the wide-vector file (dst_file=2) with legacy encoding (enc=0) writes the scalar into the low bits, clears the rest of bits 127:0, and leaves bits 511:128 unchanged.
- R4: A legal move into the wide-vector file with enc=1 or enc=2 clears every bit above the scalar, up to and including bit 511.
- R5: A legal 64-bit move into the wide-vector file writes bits 63:0 from the source and clears bits 127:64.
- R6: A move into the general-purpose file (dst_file=0) takes the low 64 bits of the vector source for a 64-bit move. For a 32-bit move it takes the low 32 bits and zero-extends them to 64 bits.
- R7: The move is 64-bit only when both `width64` and `long_mode` are 1. When `long_mode` is 0 the move is 32-bit, whatever the value of `width64`.
- R8: A request with enc=1 and `vlen`=1 faults.
- R9: With enc=1 or enc=2, a spare field other than 4'b1111 faults. With enc=0 the spare field has no effect.
- R10: The request faults when enc=3, when either file code is 3, when source and destination file are equal, or when neither side is the general-purpose file.
- R11: A request that uses the short-vector file on either side with enc other than 0 faults.
- R12: `fault_o` or `done_o` is high for exactly one cycle, in the cycle after a request, and the two are never high together. A faulting request changes no register.
- R13: A debug write (`dbg_we`=1) stores `dbg_wdata` into register `dbg_idx` of file `dbg_file` only in a cycle without a request. While a request is present the debug write is ignored. `dbg_rdata` shows the addressed register one cycle later, zero-extended to 512 bits, and reads as zero for file code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Move request strobe |
| src_file | input | 2 | Source file code |
| dst_file | input | 2 | Destination file code |
| width64 | input | 1 | Requests a 64-bit move |
| long_mode | input | 1 | 64-bit operating mode flag |
| enc | input | 2 | Encoding class |
| vlen | input | 1 | Vector-length bit |
| spare | input | 4 | Spare register field |
| src_idx | input | 3 | Source register index |
| dst_idx | input | 3 | Destination register index |
| dbg_we | input | 1 | Debug write enable |
| dbg_file | input | 2 | Debug file code |
| dbg_idx | input | 3 | Debug register index |
| dbg_wdata | input | 512 | Debug write data |
| fault_o | output | 1 | Invalid-encoding pulse |
| done_o | output | 1 | Successful-move pulse |
| dbg_rdata | output | 512 | Debug read data |

## Verification
The assertions assume that `req_valid` and every request field are stable across each active edge. They also assume that a debug write never needs to succeed in a cycle that carries a request. The bench drives all inputs on the falling edge and holds each request for exactly one cycle. It issues debug writes in separate cycles, except for the single deliberate overlap that exercises the ignore rule. The sweep covers every file pair, encoding class, width, mode, vector-length value and three spare values. Illegal combinations are therefore reached on purpose, and each is then checked against the reference model for an unchanged destination.

// File: rtl/svmove_pkg.sv
package svmove_pkg;

  typedef enum logic [1:0] {
    FILE_GPR   = 2'd0,
    FILE_SHORT = 2'd1,
    FILE_WIDE  = 2'd2,
    FILE_NONE  = 2'd3
  } file_e;

  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX3   = 2'd1,
    ENC_VEX4   = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_e;

  localparam logic [3:0] SPARE_OK = 4'b1111;

  // Decoded action for one request
  typedef struct packed {
    logic fault;
    logic eff64;
    logic src_wide;
    logic wr_gpr;
    logic wr_short;
    logic wr_wide_lo;
    logic wr_wide_hi;
  } plan_t;

endpackage

// File: rtl/svmove_decode.sv
module svmove_decode
  import svmove_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] src_file,
  input  logic [1:0] dst_file,
  input  logic       width64,
  input  logic       long_mode,
  input  logic [1:0] enc,
  input  logic       vlen,
  input  logic [3:0] spare,
  output plan_t      plan
);

  logic bad;
  logic ok;

  always_comb begin
    bad = 1'b0;
    if (enc == ENC_RSVD) bad = 1'b1;
    if (src_file == FILE_NONE || dst_file == FILE_NONE) bad = 1'b1;
    if (src_file == dst_file) bad = 1'b1;
    if (src_file != FILE_GPR && dst_file != FILE_GPR) bad = 1'b1;
    if (enc != ENC_LEGACY && spare != SPARE_OK) bad = 1'b1;
    if (enc == ENC_VEX3 && vlen) bad = 1'b1;
    if ((src_file == FILE_SHORT || dst_file == FILE_SHORT) && enc != ENC_LEGACY)
      bad = 1'b1;
  end

  assign ok = valid & ~bad;

  always_comb begin
    plan.fault      = valid & bad;
    plan.eff64      = width64 & long_mode;
    plan.src_wide   = (src_file == FILE_WIDE);
    plan.wr_gpr     = ok && (dst_file == FILE_GPR);
    plan.wr_short   = ok && (dst_file == FILE_SHORT);
    plan.wr_wide_lo = ok && (dst_file == FILE_WIDE);
    plan.wr_wide_hi = ok && (dst_file == FILE_WIDE) && (enc != ENC_LEGACY);
  end

endmodule

// File: rtl/svmove_regfile.sv
module svmove_regfile #(
  parameter  int DEPTH = 8,
  parameter  int WIDTH = 64,
  parameter  int N_RD  = 1,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr [N_RD],
  output logic [WIDTH-1:0] rdata [N_RD]
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end

endmodule

// File: rtl/svmove_unit.sv
module svmove_unit
  import svmove_pkg::*;
#(
  parameter  int N_REG  = 8,
  parameter  int GPR_W  = 64,
  parameter  int LANE_W = 128,
  parameter  int WV_W   = 512,
  localparam int IDX_W  = $clog2(N_REG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       src_file,
  input  logic [1:0]       dst_file,
  input  logic             width64,
  input  logic             long_mode,
  input  logic [1:0]       enc,
  input  logic             vlen,
  input  logic [3:0]       spare,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             dbg_we,
  input  logic [1:0]       dbg_file,
  input  logic [IDX_W-1:0] dbg_idx,
  input  logic [WV_W-1:0]  dbg_wdata,
  output logic             fault_o,
  output logic             done_o,
  output logic [WV_W-1:0]  dbg_rdata
);

  localparam int DW    = GPR_W / 2;
  localparam int MID_W = LANE_W - GPR_W;
  localparam int HI_W  = WV_W - LANE_W;

  plan_t plan;

  svmove_decode u_dec (
    .valid     (req_valid),
    .src_file  (src_file),
    .dst_file  (dst_file),
    .width64   (width64),
    .long_mode (long_mode),
    .enc       (enc),
    .vlen      (vlen),
    .spare     (spare),
    .plan      (plan)
  );

  // Debug writes only in request-free cycles
  logic             dbg_go;
  logic [IDX_W-1:0] wr_addr;
  assign dbg_go  = dbg_we & ~req_valid;
  assign wr_addr = dbg_go ? dbg_idx : dst_idx;

  logic [IDX_W-1:0] ra2 [2];
  logic [IDX_W-1:0] ra1 [1];
  assign ra2[0] = src_idx;
  assign ra2[1] = dbg_idx;
  assign ra1[0] = dbg_idx;

  logic [GPR_W-1:0] gpr_rd [2];
  logic [GPR_W-1:0] sv_rd  [2];
  logic [GPR_W-1:0] wsc_rd [2];
  logic [MID_W-1:0] wmid_rd [1];
  logic [HI_W-1:0]  whi_rd  [1];

  // Scalar datapath
  logic [GPR_W-1:0] vec_low, scalar_in, moved;
  assign vec_low   = plan.src_wide ? wsc_rd[0] : sv_rd[0];
  assign scalar_in = (src_file == FILE_GPR) ? gpr_rd[0] : vec_low;
  assign moved     = plan.eff64 ? scalar_in
                                : {{(GPR_W-DW){1'b0}}, scalar_in[DW-1:0]};

  logic gpr_we, sv_we, wsc_we, wmid_we, whi_we;
  logic [GPR_W-1:0] gpr_wd, sv_wd, wsc_wd;
  logic [MID_W-1:0] wmid_wd;
  logic [HI_W-1:0]  whi_wd;

  assign gpr_we  = plan.wr_gpr     | (dbg_go && dbg_file == FILE_GPR);
  assign sv_we   = plan.wr_short   | (dbg_go && dbg_file == FILE_SHORT);
  assign wsc_we  = plan.wr_wide_lo | (dbg_go && dbg_file == FILE_WIDE);
  assign wmid_we = plan.wr_wide_lo | (dbg_go && dbg_file == FILE_WIDE);
  assign whi_we  = plan.wr_wide_hi | (dbg_go && dbg_file == FILE_WIDE);

  assign gpr_wd  = dbg_go ? dbg_wdata[GPR_W-1:0]      : moved;
  assign sv_wd   = dbg_go ? dbg_wdata[GPR_W-1:0]      : moved;
  assign wsc_wd  = dbg_go ? dbg_wdata[GPR_W-1:0]      : moved;
  assign wmid_wd = dbg_go ? dbg_wdata[LANE_W-1:GPR_W] : '0;
  assign whi_wd  = dbg_go ? dbg_wdata[WV_W-1:LANE_W]  : '0;

  svmove_regfile #(.DEPTH(N_REG), .WIDTH(GPR_W), .N_RD(2)) u_gpr (
    .clk(clk), .we(gpr_we), .waddr(wr_addr), .wdata(gpr_wd),
    .raddr(ra2), .rdata(gpr_rd));

  svmove_regfile #(.DEPTH(N_REG), .WIDTH(GPR_W), .N_RD(2)) u_short (
    .clk(clk), .we(sv_we), .waddr(wr_addr), .wdata(sv_wd),
    .raddr(ra2), .rdata(sv_rd));

  svmove_regfile #(.DEPTH(N_REG), .WIDTH(GPR_W), .N_RD(2)) u_wide_sc (
    .clk(clk), .we(wsc_we), .waddr(wr_addr), .wdata(wsc_wd),
    .raddr(ra2), .rdata(wsc_rd));

  svmove_regfile #(.DEPTH(N_REG), .WIDTH(MID_W), .N_RD(1)) u_wide_mid (
    .clk(clk), .we(wmid_we), .waddr(wr_addr), .wdata(wmid_wd),
    .raddr(ra1), .rdata(wmid_rd));

  svmove_regfile #(.DEPTH(N_REG), .WIDTH(HI_W), .N_RD(1)) u_wide_hi (
    .clk(clk), .we(whi_we), .waddr(wr_addr), .wdata(whi_wd),
    .raddr(ra1), .rdata(whi_rd));

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_o   <= 1'b0;
      done_o    <= 1'b0;
      dbg_rdata <= '0;
    end else begin
      fault_o <= plan.fault;
      done_o  <= req_valid & ~plan.fault;
      case (file_e'(dbg_file))
        FILE_GPR:   dbg_rdata <= {{(WV_W-GPR_W){1'b0}}, gpr_rd[1]};
        FILE_SHORT: dbg_rdata <= {{(WV_W-GPR_W){1'b0}}, sv_rd[1]};
        FILE_WIDE:  dbg_rdata <= {whi_rd[0], wmid_rd[0], wsc_rd[1]};
        default:    dbg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/svmove_checker.sv
module svmove_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] src_file,
  input logic [1:0] dst_file,
  input logic [1:0] enc,
  input logic       vlen,
  input logic [3:0] spare,
  input logic       fault_o,
  input logic       done_o,
  input logic       any_we,
  input logic       hi_we
);

  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(fault_o && done_o));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fault_o && !done_o));

  p_fault_nowrite_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid && (src_file == dst_file) |-> !any_we);

  p_vlen_fault_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && enc == 2'd1 && vlen |=> fault_o);

  p_spare_fault_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && (enc == 2'd1 || enc == 2'd2) && spare != 4'b1111 |=> fault_o);

  p_same_file_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && src_file == dst_file |=> fault_o);

  p_short_legacy_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid && (src_file == 2'd1 || dst_file == 2'd1) && enc != 2'd0 |=> fault_o);

  p_keep_upper_r3: assert property (@(posedge clk) disable iff (rst)
    req_valid && enc == 2'd0 |-> !hi_we);

endmodule

bind svmove_unit svmove_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .src_file  (src_file),
  .dst_file  (dst_file),
  .enc       (enc),
  .vlen      (vlen),
  .spare     (spare),
  .fault_o   (fault_o),
  .done_o    (done_o),
  .any_we    (gpr_we | sv_we | wsc_we | wmid_we | whi_we),
  .hi_we     (whi_we)
);

// File: tb/svmove_unit_bench.sv
module svmove_unit_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [1:0]   src_file = '0, dst_file = '0, enc = '0, dbg_file = '0;
  logic         width64 = 1'b0, long_mode = 1'b0, vlen = 1'b0, dbg_we = 1'b0;
  logic [3:0]   spare = 4'hF;
  logic [2:0]   src_idx = '0, dst_idx = '0, dbg_idx = '0;
  logic [511:0] dbg_wdata = '0;
  logic         fault_o, done_o;
  logic [511:0] dbg_rdata;

  int n_checks = 0;
  int n_fail = 0;

  logic [63:0]  m_gpr [8];
  logic [63:0]  m_sv  [8];
  logic [511:0] m_wv  [8];

  always #10 clk = ~clk;

  svmove_unit u_svmove_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .src_file(src_file),
    .dst_file(dst_file), .width64(width64), .long_mode(long_mode), .enc(enc),
    .vlen(vlen), .spare(spare), .src_idx(src_idx), .dst_idx(dst_idx),
    .dbg_we(dbg_we), .dbg_file(dbg_file), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .fault_o(fault_o), .done_o(done_o),
    .dbg_rdata(dbg_rdata));

  task automatic chk(input bit ok, input string tag,
                     input logic [511:0] act, input logic [511:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [511:0] pat(input int s);
    logic [511:0] r;
    for (int j = 0; j < 16; j++)
      r[j*32 +: 32] = 32'((s + 1) * 32'h9E3779B1) ^ 32'(j * 32'h01000193 + j + 7);
    return r;
  endfunction

  function automatic logic [511:0] model_get(input int f, input int i);
    case (f)
      0: return {448'b0, m_gpr[i]};
      1: return {448'b0, m_sv[i]};
      2: return m_wv[i];
      default: return '0;
    endcase
  endfunction

  task automatic dbg_write(input int f, input int i, input logic [511:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_file = 2'(f); dbg_idx = 3'(i); dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
    case (f)
      0: m_gpr[i] = d[63:0];
      1: m_sv[i]  = d[63:0];
      2: m_wv[i]  = d;
      default: ;
    endcase
  endtask

  task automatic dbg_read(input int f, input int i, output logic [511:0] d);
    @(negedge clk);
    dbg_file = 2'(f); dbg_idx = 3'(i);
    @(negedge clk);
    d = dbg_rdata;
  endtask

  task automatic load_all(input int seed);
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 8; i++)
        dbg_write(f, i, pat(seed * 31 + f * 8 + i));
  endtask

  // Expected legality straight from the requirement text
  function automatic string fault_tag(input int sf, input int df, input int e,
                                      input int vl, input int sp);
    if (e == 3) return "R10";
    if (sf == 3 || df == 3 || sf == df || (sf != 0 && df != 0)) return "R10";
    if (e != 0 && (sf == 1 || df == 1)) return "R11";
    if (e == 1 && vl == 1) return "R8";
    if (e != 0 && sp != 15) return "R9";
    return "";
  endfunction

  task automatic run_op(input int sf, input int df, input int w, input int lm,
                        input int e, input int vl, input int sp,
                        input int si, input int di);
    string        ftag, wtag;
    bit           bad;
    bit           eff64;
    logic [63:0]  v, mv;
    logic [511:0] exp_dst, got;
    ftag  = fault_tag(sf, df, e, vl, sp);
    bad   = (ftag != "");
    eff64 = (w == 1) && (lm == 1);
    case (sf)
      0: v = m_gpr[si];
      1: v = m_sv[si];
      default: v = m_wv[si][63:0];
    endcase
    mv = eff64 ? v : {32'b0, v[31:0]};
    if (!bad) begin
      case (df)
        0: m_gpr[di] = mv;
        1: m_sv[di]  = mv;
        2: m_wv[di]  = (e == 0) ? {m_wv[di][511:128], 64'b0, mv} : {448'b0, mv};
        default: ;
      endcase
    end
    exp_dst = model_get(df, di);
    if (bad) wtag = (ftag == "R9" || ftag == "R8") ? ftag : "R12";
    else if (w == 1 && lm == 0) wtag = "R7";
    else if (df == 0) wtag = "R6";
    else if (df == 1) wtag = "R2";
    else if (eff64) wtag = "R5";
    else wtag = (e == 0) ? "R3" : "R4";

    @(negedge clk);
    req_valid = 1'b1; src_file = 2'(sf); dst_file = 2'(df); width64 = w[0];
    long_mode = lm[0]; enc = 2'(e); vlen = vl[0]; spare = 4'(sp);
    src_idx = 3'(si); dst_idx = 3'(di);
    @(negedge clk);
    req_valid = 1'b0;
    chk(fault_o == bad && done_o == !bad, bad ? ftag : "R12",
        {510'b0, fault_o, done_o}, {510'b0, bad, !bad});
    dbg_file = 2'(df); dbg_idx = 3'(di);
    @(negedge clk);
    got = dbg_rdata;
    chk(got == exp_dst, wtag, got, exp_dst);
    chk(!fault_o && !done_o, "R12", {510'b0, fault_o, done_o}, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [511:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!fault_o && !done_o, "R1", {510'b0, fault_o, done_o}, '0);
    chk(dbg_rdata == '0, "R1", dbg_rdata, '0);

    load_all(1);
    // R13 debug write then read back
    dbg_write(2, 5, pat(99));
    dbg_read(2, 5, d);
    chk(d == pat(99), "R13", d, pat(99));
    dbg_write(0, 3, pat(77));
    dbg_read(0, 3, d);
    chk(d == {448'b0, pat(77)[63:0]}, "R13", d, {448'b0, pat(77)[63:0]});
    dbg_read(3, 3, d);
    chk(d == '0, "R13", d, '0);

    // R13 debug write ignored while a request is present
    @(negedge clk);
    req_valid = 1'b1; src_file = 2'd0; dst_file = 2'd1; enc = 2'd0;
    width64 = 1'b1; long_mode = 1'b1; vlen = 1'b0; spare = 4'hF;
    src_idx = 3'd0; dst_idx = 3'd4;
    dbg_we = 1'b1; dbg_file = 2'd2; dbg_idx = 3'd6; dbg_wdata = '1;
    @(negedge clk);
    req_valid = 1'b0; dbg_we = 1'b0;
    m_sv[4] = m_gpr[0];
    dbg_read(2, 6, d);
    chk(d == m_wv[6], "R13", d, m_wv[6]);
    dbg_read(1, 4, d);
    chk(d == {448'b0, m_sv[4]}, "R2", d, {448'b0, m_sv[4]});

    // Sweep over the full request space
    n = 0;
    for (int sf = 0; sf < 4; sf++)
      for (int df = 0; df < 4; df++)
        for (int e = 0; e < 4; e++)
          for (int w = 0; w < 2; w++)
            for (int lm = 0; lm < 2; lm++)
              for (int vl = 0; vl < 2; vl++)
                for (int k = 0; k < 3; k++) begin
                  if (n % 64 == 0) load_all(n + 2);
                  run_op(sf, df, w, lm, e, vl, (k == 0) ? 15 : (k == 1) ? 0 : 7,
                         n % 8, (n * 5 + 3) % 8);
                  n++;
                end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule